// File: doc/BRIEF.md
# Trace Capture Buffer Controller

This block stores incoming trace message words in a circular on-chip buffer and decides when recording ends. A host arms it by raising the main switch; from then on every valid message is written at the write pointer, which wraps modulo the buffer depth. The mode and the trigger placement are sampled once, at arming, so a run cannot change character halfway through.

Three recording modes exist. One-shot fills the buffer once and stops, whatever triggers arrive. Trigger mode records around the first trigger pulse, keeping a fixed share of the buffer as history before it and filling the rest after it. Continuous mode wraps until the main switch drops or the CPU stops, and can be told to raise a halt request when the buffer fills; once the host has drained the buffer, recording restarts from empty on its own. The wrap flag and the latched trigger address let a reader locate the oldest entry and the trigger point. The depth is a power of two, at least 16.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset, wr_ptr, wrapped, trig_seen, trig_addr, done, halt_req and rd_valid are all 0.
- R2: A rising edge of rec_on clears the write and read pointers, wrapped, trig_seen, done and halt_req and samples mode_sel, pos_sel and halt_on_full; from the next cycle each valid message is written at wr_ptr, wr_ptr advances modulo DEPTH, and wrapped goes to 1 when slot DEPTH-1 is written.
- R3: While rec_on is 0 or cpu_halted is 1, messages are not stored and triggers are not taken.
- R4: mode_sel 0 (one-shot): done rises when slot DEPTH-1 is written; triggers are ignored and trig_seen stays 0; later messages leave wr_ptr unchanged.
- R5: mode_sel 1 (trigger): the first cycle in which any trig_evt bit is high sets trig_seen and records the write pointer of that cycle in trig_addr; later trigger pulses change neither.
- R6: In trigger mode, pos_sel 0 keeps DEPTH/16 entries before the trigger, pos_sel 1 or 3 keeps DEPTH/2 and pos_sel 2 keeps DEPTH-DEPTH/16; done rises once DEPTH minus that amount messages have been stored counting from the trigger cycle, a message in the trigger cycle counting first.
- R7: mode_sel 2 or 3 (continuous): the buffer wraps without end, done stays 0 and triggers are ignored.
- R8: In continuous mode with halt_on_full set, writing slot DEPTH-1 raises halt_req and further messages are ignored.
- R9: A read request is accepted only while rec_on is 0, done is 1 or halt_req is 1; an accepted request gives rd_valid high in the next cycle with rd_data holding the entry at the read pointer, which then advances; otherwise rd_valid stays 0.
- R10: rd_rewind sets the read pointer to the oldest entry (wr_ptr when wrapped is 1, else 0) and takes priority over a read request in the same cycle, which is then not accepted.
- R11: While halt_req is 1, the accepted read of slot DEPTH-1 clears halt_req, wr_ptr and wrapped, and recording continues from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_on | input | 1 | Main switch; rising edge arms, low stops recording |
| cpu_halted | input | 1 | CPU stopped; freezes recording |
| msg_valid | input | 1 | Trace message present |
| msg_data | input | WIDTH | Trace message word |
| trig_evt | input | NTRIG | Trigger event pulses, OR-combined |
| mode_sel | input | 2 | 0 one-shot, 1 trigger, 2/3 continuous |
| pos_sel | input | 2 | 0 begin, 1/3 center, 2 end |
| halt_on_full | input | 1 | Raise halt request when buffer fills (continuous) |
| rd_en | input | 1 | Read one entry |
| rd_rewind | input | 1 | Move read pointer to oldest entry |
| wr_ptr | output | log2(DEPTH) | Next slot to be written |
| wrapped | output | 1 | Buffer has wrapped at least once |
| trig_seen | output | 1 | Trigger taken in this run |
| trig_addr | output | log2(DEPTH) | Slot that was current at the trigger |
| done | output | 1 | Recording finished |
| halt_req | output | 1 | Halt request, buffer full |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | WIDTH | Read data |

## Verification
The trigger and a message store can fall in the same cycle, and then that message must both sit at trig_addr and count as the first post-trigger entry. The bench provokes it by raising msg_valid together with a trigger pulse at every trigger position, including the end position where the single post-trigger slot makes the trigger cycle also the finishing cycle, and the same scenario without the coincident message. It judges each run by the number of messages stored until done, by trig_addr and by the final pointer and wrap flag, and then reads the whole buffer back from the oldest entry.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_TRIGGER = 2'd1,
    MODE_CONT    = 2'd2
  } tcb_mode_e;

  typedef enum logic [1:0] {
    POS_BEGIN  = 2'd0,
    POS_CENTER = 2'd1,
    POS_END    = 2'd2
  } tcb_pos_e;

  function automatic tcb_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'd0:    return MODE_ONESHOT;
      2'd1:    return MODE_TRIGGER;
      default: return MODE_CONT;
    endcase
  endfunction

  function automatic tcb_pos_e decode_pos(input logic [1:0] sel);
    case (sel)
      2'd0:    return POS_BEGIN;
      2'd2:    return POS_END;
      default: return POS_CENTER;
    endcase
  endfunction

  // entries kept ahead of the trigger
  function automatic int unsigned pre_depth(input tcb_pos_e p, input int unsigned depth);
    case (p)
      POS_BEGIN: return depth / 16;
      POS_END:   return depth - depth / 16;
      default:   return depth / 2;
    endcase
  endfunction

  // entries written from the trigger cycle on
  function automatic int unsigned post_depth(input tcb_pos_e p, input int unsigned depth);
    return depth - pre_depth(p, depth);
  endfunction

endpackage

// File: rtl/tcb_store_ram.sv
module tcb_store_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/tcb_recorder.sv
module tcb_recorder
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned NTRIG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rec_on,
  input  logic                     cpu_halted,
  input  logic                     msg_valid,
  input  logic [NTRIG-1:0]         trig_evt,
  input  logic [1:0]               mode_sel,
  input  logic [1:0]               pos_sel,
  input  logic                     halt_on_full,
  input  logic                     resume_i,
  output logic [$clog2(DEPTH)-1:0] wr_ptr_o,
  output logic                     wrapped_o,
  output logic                     trig_seen_o,
  output logic [$clog2(DEPTH)-1:0] trig_addr_o,
  output logic                     done_o,
  output logic                     halt_req_o,
  output logic                     store_o,
  output logic                     start_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic      rec_q;
  tcb_mode_e mode_q;
  tcb_pos_e  pos_q;
  logic      hof_q;
  logic [CW-1:0] post_left;

  // named internal events
  logic          start_w, capture_w, store_w, last_slot_w, take_trig_w;
  logic [CW-1:0] post_full_w, post_load_w;

  assign start_w     = rec_on & ~rec_q;
  assign capture_w   = rec_on & rec_q & ~done_o & ~halt_req_o & ~cpu_halted;
  assign store_w     = capture_w & msg_valid;
  assign last_slot_w = (wr_ptr_o == AW'(DEPTH - 1));
  assign take_trig_w = capture_w & (mode_q == MODE_TRIGGER) & ~trig_seen_o & (|trig_evt);
  assign post_full_w = CW'(post_depth(pos_q, DEPTH));
  assign post_load_w = post_full_w - {{(CW-1){1'b0}}, store_w};

  assign store_o = store_w;
  assign start_o = start_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q       <= 1'b0;
      mode_q      <= MODE_ONESHOT;
      pos_q       <= POS_BEGIN;
      hof_q       <= 1'b0;
      post_left   <= '0;
      wr_ptr_o    <= '0;
      wrapped_o   <= 1'b0;
      trig_seen_o <= 1'b0;
      trig_addr_o <= '0;
      done_o      <= 1'b0;
      halt_req_o  <= 1'b0;
    end else begin
      rec_q <= rec_on;
      if (start_w) begin
        mode_q      <= decode_mode(mode_sel);
        pos_q       <= decode_pos(pos_sel);
        hof_q       <= halt_on_full;
        post_left   <= '0;
        wr_ptr_o    <= '0;
        wrapped_o   <= 1'b0;
        trig_seen_o <= 1'b0;
        trig_addr_o <= '0;
        done_o      <= 1'b0;
        halt_req_o  <= 1'b0;
      end else if (resume_i) begin
        wr_ptr_o   <= '0;
        wrapped_o  <= 1'b0;
        halt_req_o <= 1'b0;
      end else begin
        if (store_w) begin
          wr_ptr_o <= wr_ptr_o + AW'(1);
          if (last_slot_w) wrapped_o <= 1'b1;
        end
        case (mode_q)
          MODE_ONESHOT: begin
            if (store_w && last_slot_w) done_o <= 1'b1;
          end
          MODE_CONT: begin
            if (store_w && last_slot_w && hof_q) halt_req_o <= 1'b1;
          end
          default: begin
            if (take_trig_w) begin
              trig_seen_o <= 1'b1;
              trig_addr_o <= wr_ptr_o;
              post_left   <= post_load_w;
              if (post_load_w == '0) done_o <= 1'b1;
            end else if (trig_seen_o && store_w) begin
              post_left <= post_left - CW'(1);
              if (post_left == CW'(1)) done_o <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  assert_off_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_on && !halt_req_o) |=> $stable(wr_ptr_o));

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && rec_on && rec_q) |=> done_o);

  assert_first_trig_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_seen_o && !start_w) |=> (trig_seen_o && $stable(trig_addr_o)));

  assert_countdown_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_seen_o && !done_o) |-> (post_left != '0));

  assert_cont_never_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mode_q != MODE_CONT));

  assert_halt_only_cont_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req_o |-> (mode_q == MODE_CONT));
endmodule

// File: rtl/tcb_reader.sv
module tcb_reader #(
  parameter int unsigned DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     rd_rewind,
  input  logic                     rec_on,
  input  logic                     done_i,
  input  logic                     halt_req_i,
  input  logic                     start_i,
  input  logic [$clog2(DEPTH)-1:0] oldest_i,
  output logic [$clog2(DEPTH)-1:0] rd_ptr_o,
  output logic                     rd_take_o,
  output logic                     resume_o,
  output logic                     rd_valid_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic rd_ok_w;

  assign rd_ok_w   = ~rec_on | done_i | halt_req_i;
  assign rd_take_o = rd_en & ~rd_rewind & ~start_i & rd_ok_w;
  assign resume_o  = rd_take_o & halt_req_i & (rd_ptr_o == AW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_o   <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_take_o;
      if (start_i)        rd_ptr_o <= '0;
      else if (rd_rewind) rd_ptr_o <= oldest_i;
      else if (resume_o)  rd_ptr_o <= '0;
      else if (rd_take_o) rd_ptr_o <= rd_ptr_o + AW'(1);
    end
  end

  assert_read_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rec_on && !done_i && !halt_req_i) |=> !rd_valid_o);

  assert_rewind_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rewind && !start_i) |=> (!rd_valid_o && rd_ptr_o == $past(oldest_i)));

  assert_resume_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !halt_req_i);
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NTRIG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rec_on,
  input  logic                     cpu_halted,
  input  logic                     msg_valid,
  input  logic [WIDTH-1:0]         msg_data,
  input  logic [NTRIG-1:0]         trig_evt,
  input  logic [1:0]               mode_sel,
  input  logic [1:0]               pos_sel,
  input  logic                     halt_on_full,
  input  logic                     rd_en,
  input  logic                     rd_rewind,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic                     wrapped,
  output logic                     trig_seen,
  output logic [$clog2(DEPTH)-1:0] trig_addr,
  output logic                     done,
  output logic                     halt_req,
  output logic                     rd_valid,
  output logic [WIDTH-1:0]         rd_data
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          store_w, start_w, resume_w, rd_take_w;
  logic [AW-1:0] rd_ptr_w, oldest_w;

  assign oldest_w = wrapped ? wr_ptr : '0;

  tcb_recorder #(.DEPTH(DEPTH), .NTRIG(NTRIG)) rec_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rec_on       (rec_on),
    .cpu_halted   (cpu_halted),
    .msg_valid    (msg_valid),
    .trig_evt     (trig_evt),
    .mode_sel     (mode_sel),
    .pos_sel      (pos_sel),
    .halt_on_full (halt_on_full),
    .resume_i     (resume_w),
    .wr_ptr_o     (wr_ptr),
    .wrapped_o    (wrapped),
    .trig_seen_o  (trig_seen),
    .trig_addr_o  (trig_addr),
    .done_o       (done),
    .halt_req_o   (halt_req),
    .store_o      (store_w),
    .start_o      (start_w)
  );

  tcb_reader #(.DEPTH(DEPTH)) rdr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_rewind  (rd_rewind),
    .rec_on     (rec_on),
    .done_i     (done),
    .halt_req_i (halt_req),
    .start_i    (start_w),
    .oldest_i   (oldest_w),
    .rd_ptr_o   (rd_ptr_w),
    .rd_take_o  (rd_take_w),
    .resume_o   (resume_w),
    .rd_valid_o (rd_valid)
  );

  tcb_store_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) ram_i (
    .clk   (clk),
    .we    (store_w),
    .waddr (wr_ptr),
    .wdata (msg_data),
    .re    (rd_take_w),
    .raddr (rd_ptr_w),
    .rdata (rd_data)
  );

  assert_reset_clean_R1: assert property (@(posedge clk)
    !rst_n |=> (!done && !halt_req && !trig_seen && !rd_valid));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_w && !start_w && !resume_w) |=> (wr_ptr == $past(wr_ptr) + AW'(1)));
endmodule

// File: tb/trace_capture_ctrl_tb_top.sv
module trace_capture_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int NTRIG = 3;

  // trigger-mode scenarios: position, messages before trigger, message in
  // trigger cycle, expected post count, trigger slot, final pointer, wrap
  localparam int NV = 5;
  localparam int V_POS   [NV] = '{0, 1, 2, 2, 1};
  localparam int V_NPRE  [NV] = '{3, 20, 5, 0, 2};
  localparam int V_SAME  [NV] = '{0, 1, 1, 0, 0};
  localparam int V_POST  [NV] = '{15, 8, 1, 1, 8};
  localparam int V_TADDR [NV] = '{3, 4, 5, 0, 2};
  localparam int V_WR    [NV] = '{2, 12, 6, 1, 10};
  localparam int V_WRAP  [NV] = '{1, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec_on = 1'b0, cpu_halted = 1'b0, msg_valid = 1'b0;
  logic [WIDTH-1:0] msg_data = '0;
  logic [NTRIG-1:0] trig_evt = '0;
  logic [1:0] mode_sel = '0, pos_sel = '0;
  logic halt_on_full = 1'b0, rd_en = 1'b0, rd_rewind = 1'b0;
  logic [3:0] wr_ptr, trig_addr;
  logic wrapped, trig_seen, done, halt_req, rd_valid;
  logic [WIDTH-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int seq = 0;

  always #4 clk = ~clk;

  trace_capture_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NTRIG(NTRIG)) dut_i (
    .clk(clk), .rst_n(rst_n), .rec_on(rec_on), .cpu_halted(cpu_halted),
    .msg_valid(msg_valid), .msg_data(msg_data), .trig_evt(trig_evt),
    .mode_sel(mode_sel), .pos_sel(pos_sel), .halt_on_full(halt_on_full),
    .rd_en(rd_en), .rd_rewind(rd_rewind), .wr_ptr(wr_ptr), .wrapped(wrapped),
    .trig_seen(trig_seen), .trig_addr(trig_addr), .done(done),
    .halt_req(halt_req), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic report();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_msg();
    msg_valid = 1'b1;
    msg_data  = WIDTH'(seq);
    seq++;
    tick();
    msg_valid = 1'b0;
  endtask

  task automatic arm(input int m, input int p, input logic hof);
    rec_on = 1'b0;
    tick();
    mode_sel = 2'(m);
    pos_sel = 2'(p);
    halt_on_full = hof;
    rec_on = 1'b1;
    tick();
    seq = 0;
  endtask

  task automatic read_one(output int d, output int v);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    v = int'(rd_valid);
    d = int'(rd_data);
  endtask

  task automatic rewind();
    rd_rewind = 1'b1;
    tick();
    rd_rewind = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1..: act=expired exp=finished");
    report();
  end

  initial begin : main
    int d, v, cnt, total, oldest, nread, errs;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 wr_ptr", int'(wr_ptr), 0);
    chk("R1 flags", int'({wrapped, trig_seen, done, halt_req, rd_valid}), 0);
    chk("R1 trig_addr", int'(trig_addr), 0);

    // R5 R6 table of trigger-mode runs
    for (int i = 0; i < NV; i++) begin
      arm(1, V_POS[i], 1'b0);
      repeat (V_NPRE[i]) send_msg();
      trig_evt = 3'b010;
      msg_valid = V_SAME[i] != 0;
      msg_data = WIDTH'(seq);
      if (V_SAME[i] != 0) seq++;
      tick();
      trig_evt = '0;
      msg_valid = 1'b0;
      cnt = V_SAME[i];
      while (!done && cnt < 40) begin
        send_msg();
        cnt++;
      end
      chk($sformatf("R6 post count v%0d", i), cnt, V_POST[i]);
      chk($sformatf("R5 trig_addr v%0d", i), int'(trig_addr), V_TADDR[i]);
      chk($sformatf("R5 trig_seen v%0d", i), int'(trig_seen), 1);
      chk($sformatf("R2 wr_ptr v%0d", i), int'(wr_ptr), V_WR[i]);
      chk($sformatf("R2 wrapped v%0d", i), int'(wrapped), V_WRAP[i]);
      total = V_NPRE[i] + V_POST[i];
      oldest = (total > DEPTH) ? total - DEPTH : 0;
      nread = (total > DEPTH) ? DEPTH : total;
      rewind();
      errs = 0;
      for (int k = 0; k < nread; k++) begin
        read_one(d, v);
        if (v != 1 || d != ((oldest + k) & 8'hFF)) errs++;
      end
      chk($sformatf("R10 readout from oldest v%0d", i), errs, 0);
    end

    // R4 one-shot, triggers ignored
    arm(0, 1, 1'b0);
    for (int k = 0; k < 15; k++) begin
      trig_evt = (k == 5) ? 3'b001 : 3'b000;
      send_msg();
    end
    trig_evt = '0;
    chk("R4 not done before full", int'(done), 0);
    send_msg();
    chk("R4 done when full", int'(done), 1);
    chk("R4 trig ignored", int'(trig_seen), 0);
    chk("R2 wrapped at full", int'(wrapped), 1);
    send_msg();
    chk("R4 later msg ignored", int'(wr_ptr), 0);
    rewind();
    errs = 0;
    for (int k = 0; k < DEPTH; k++) begin
      read_one(d, v);
      if (v != 1 || d != k) errs++;
    end
    chk("R9 one-shot readout", errs, 0);
    rd_en = 1'b1;
    rd_rewind = 1'b1;
    tick();
    rd_en = 1'b0;
    rd_rewind = 1'b0;
    chk("R10 rewind blocks read", int'(rd_valid), 0);
    read_one(d, v);
    chk("R10 after rewind oldest", d, 0);

    // R3 R7 R9 continuous
    arm(2, 0, 1'b0);
    repeat (3) send_msg();
    read_one(d, v);
    chk("R9 read refused while recording", v, 0);
    cpu_halted = 1'b1;
    send_msg();
    cpu_halted = 1'b0;
    chk("R3 cpu halted no store", int'(wr_ptr), 3);
    trig_evt = 3'b100;
    tick();
    trig_evt = '0;
    chk("R7 trig ignored", int'(trig_seen), 0);
    repeat (37) send_msg();
    chk("R7 wr_ptr after 40", int'(wr_ptr), 8);
    chk("R7 wrapped", int'(wrapped), 1);
    chk("R7 never done", int'(done), 0);
    rec_on = 1'b0;
    send_msg();
    chk("R3 switch off no store", int'(wr_ptr), 8);
    rewind();
    read_one(d, v);
    chk("R10 oldest after wrap", d, 25);

    // R3 R5 R6 trigger gating and first-trigger-only
    arm(1, 1, 1'b0);
    rec_on = 1'b0;
    trig_evt = 3'b001;
    tick();
    trig_evt = '0;
    chk("R3 trig blocked when off", int'(trig_seen), 0);
    rec_on = 1'b1;
    tick();
    seq = 0;
    repeat (2) send_msg();
    trig_evt = 3'b001;
    tick();
    trig_evt = '0;
    repeat (3) send_msg();
    trig_evt = 3'b100;
    tick();
    trig_evt = '0;
    chk("R5 second trig ignored", int'(trig_addr), 2);
    repeat (4) send_msg();
    chk("R6 not done after 7", int'(done), 0);
    send_msg();
    chk("R6 done after 8", int'(done), 1);

    // R8 R11 halt on full and resume
    arm(2, 0, 1'b1);
    repeat (16) send_msg();
    chk("R8 halt raised", int'(halt_req), 1);
    send_msg();
    chk("R8 msg ignored while halted", int'(wr_ptr), 0);
    errs = 0;
    for (int k = 0; k < 15; k++) begin
      read_one(d, v);
      if (v != 1 || d != k) errs++;
    end
    chk("R10 arm resets read pointer", errs, 0);
    chk("R11 halt held before last", int'(halt_req), 1);
    read_one(d, v);
    chk("R11 last entry", d, 15);
    chk("R11 halt cleared", int'(halt_req), 0);
    chk("R11 wrapped cleared", int'(wrapped), 0);
    repeat (3) send_msg();
    chk("R11 recording resumed", int'(wr_ptr), 3);

    report();
  end
endmodule